// File: doc/BRIEF.md
# External Request Pacing and Start Control

This block decides when one DMA channel may move data, based on two external pins. With external start selected, setting the software start bit only arms the channel. Data does not move until a synchronized start pin goes high. With external pause selected, the channel begins paused. Each new assertion of the active-low request pin grants a burst of a programmed byte count. When that many bytes have been reported as moved, the channel pauses again.

The burst size is given as a base-2 code, so a code of k grants 2^k bytes, up to 1024 bytes. The data mover reports each completed unit with a one-cycle pulse and the unit's byte size. It moves data only while the run-enable output is high. Clearing the start bit returns the block to idle, whatever state it was in.

Top module: `dreq_pacer`

## Requirements
- R1: While reset is asserted and right after it is released, `run_o` and `paused_o` are both 0.
- R2: With `ext_start_en_i`=0 and `ext_pause_en_i`=0, setting `start_bit_i` raises `run_o` within two clock cycles.
- R3: With `ext_start_en_i`=1, the start bit alone leaves `run_o` and `paused_o` at 0. Both outputs stay 0 until `start_pin_i` has been high for the two-flop synchronizer delay. After that the channel runs.
- R4: When `start_bit_i` is 0 at a clock edge, both `run_o` and `paused_o` are 0 in the following cycle.
- R5: With `ext_pause_en_i`=1, a started channel holds `paused_o`=1 and `run_o`=0 until it sees a high-to-low transition of the synchronized `dreq_ni`.
- R6: Each high-to-low transition of `dreq_ni` grants a burst of 2^`req_code_i` bytes. `run_o` stays 1 until the sum of `moved_bytes_i` over the `moved_i` pulses in the burst reaches that count. In the cycle after that pulse, `run_o`=0 and `paused_o`=1.
- R7: Holding `dreq_ni` low grants only one burst. A further burst needs `dreq_ni` to go high and then low again.
- R8: A unit that overshoots the count is still completed, and the burst ends on that unit. The next burst counts from zero, so no excess carries over.
- R9: A high-to-low transition of `dreq_ni` during a running burst is ignored. The burst still ends at its original byte total.
- R10: `req_code_i` values above 10 grant 1024 bytes, the same as code 10.
- R11: With `ext_pause_en_i`=0, moved bytes never pause the channel.
- R12: `run_o` and `paused_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_bit_i | input | 1 | Software start bit level from the mode register |
| ext_start_en_i | input | 1 | Selects waiting for the external start pin |
| ext_pause_en_i | input | 1 | Selects request-paced bursts |
| req_code_i | input | 4 | Burst size as log2 of bytes |
| start_pin_i | input | 1 | External start pin, active high, asynchronous |
| dreq_ni | input | 1 | External request pin, active low, asynchronous |
| moved_i | input | 1 | One-cycle pulse per unit completed by the data mover |
| moved_bytes_i | input | 6 | Byte size of the unit reported by `moved_i` |
| run_o | output | 1 | Run-enable to the data mover |
| paused_o | output | 1 | Channel started but waiting for a request |

## Verification
Bursts are run for several pairs of code and unit size. An exact fit (8 bytes in units of 4, 4 in units of 1) shows that the count reaches its limit on the right unit. Uneven sizes (1 byte in a unit of 4, 32 bytes in units of 3) show that the final overshooting unit completes and ends the burst. A code above the maximum shows clamping to 1024 bytes. Directed sequences separate a held-low request from a fresh edge, and a mid-burst edge from a restart. A follow-up burst in units of 1 shows that overshoot does not carry over into the next burst.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PIN = 2'd1,
    ST_ACTIVE   = 2'd2
  } start_st_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dreq_start_gate.sv
module dreq_start_gate
  import dreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_bit_i,
  input  logic ext_start_en_i,
  input  logic pin_sync_i,
  output logic active_o
);
  start_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_bit_i) st_d = ext_start_en_i ? ST_WAIT_PIN : ST_ACTIVE;
      ST_WAIT_PIN: begin
        if (!start_bit_i) st_d = ST_IDLE;
        else if (pin_sync_i || !ext_start_en_i) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: if (!start_bit_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  assign active_o = (st_q == ST_ACTIVE);
endmodule

// File: rtl/dreq_burst_meter.sv
module dreq_burst_meter #(
  parameter int MAX_LOG2 = 10,
  parameter int UNIT_W   = 6,
  parameter int CODE_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              pause_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              grant_i,
  input  logic              moved_i,
  input  logic [UNIT_W-1:0] bytes_i,
  output logic              burst_on_o
);
  localparam int CNT_W = MAX_LOG2 + 1;

  logic [CODE_W-1:0] code_eff;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    sum;
  logic              burst_q;

  // codes beyond the maximum clamp to the largest burst
  assign code_eff = (code_i > CODE_W'(MAX_LOG2)) ? CODE_W'(MAX_LOG2) : code_i;
  assign limit    = CNT_W'(1) << code_eff;
  assign sum      = {1'b0, cnt_q} + (CNT_W+1)'(bytes_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!active_i || !pause_en_i) begin
      burst_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!burst_q) begin
      if (grant_i) begin
        burst_q <= 1'b1;
        cnt_q   <= '0;
      end
    end else if (moved_i) begin
      // last unit may overshoot; it completes and the burst closes
      if (sum >= {1'b0, limit}) begin
        cnt_q   <= limit;
        burst_q <= 1'b0;
      end else begin
        cnt_q   <= sum[CNT_W-1:0];
      end
    end
  end

  assign burst_on_o = burst_q;
endmodule

// File: rtl/dreq_pacer.sv
module dreq_pacer #(
  parameter int MAX_LOG2 = 10,
  parameter int UNIT_W   = 6,
  parameter int CODE_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_bit_i,
  input  logic              ext_start_en_i,
  input  logic              ext_pause_en_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              start_pin_i,
  input  logic              dreq_ni,
  input  logic              moved_i,
  input  logic [UNIT_W-1:0] moved_bytes_i,
  output logic              run_o,
  output logic              paused_o
);
  logic pin_sync;
  logic dreq_sync_n;
  logic dreq_prev_q;
  logic dreq_fall;
  logic active;
  logic burst_on;

  dreq_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (start_pin_i),
    .q_o   (pin_sync)
  );

  dreq_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b1)) u_dreq_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dreq_ni),
    .q_o   (dreq_sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dreq_prev_q <= 1'b1;
    else dreq_prev_q <= dreq_sync_n;
  end

  assign dreq_fall = dreq_prev_q & ~dreq_sync_n;

  dreq_start_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_bit_i   (start_bit_i),
    .ext_start_en_i(ext_start_en_i),
    .pin_sync_i    (pin_sync),
    .active_o      (active)
  );

  dreq_burst_meter #(.MAX_LOG2(MAX_LOG2), .UNIT_W(UNIT_W), .CODE_W(CODE_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .pause_en_i(ext_pause_en_i),
    .code_i    (req_code_i),
    .grant_i   (dreq_fall),
    .moved_i   (moved_i),
    .bytes_i   (moved_bytes_i),
    .burst_on_o(burst_on)
  );

  assign run_o    = active & (~ext_pause_en_i | burst_on);
  assign paused_o = active & ext_pause_en_i & ~burst_on;
endmodule

// File: rtl/dreq_pacer_chk.sv
module dreq_pacer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_bit_i,
  input logic ext_start_en_i,
  input logic ext_pause_en_i,
  input logic moved_i,
  input logic pin_seen,
  input logic req_edge,
  input logic run_o,
  input logic paused_o
);
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_o && paused_o));

  a_r4_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_bit_i |=> (!run_o && !paused_o));

  a_r3_wait_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_start_en_i && !pin_seen && !run_o && !paused_o) |=> (!run_o && !paused_o));

  a_r6_hold_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && ext_pause_en_i && start_bit_i && !moved_i) |=> run_o);

  a_r7_edge_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && ext_pause_en_i && $past(ext_pause_en_i) && $past(paused_o) && $past(start_bit_i))
      |-> $past(req_edge));
endmodule

bind dreq_pacer dreq_pacer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_bit_i   (start_bit_i),
  .ext_start_en_i(ext_start_en_i),
  .ext_pause_en_i(ext_pause_en_i),
  .moved_i       (moved_i),
  .pin_seen      (pin_sync),
  .req_edge      (dreq_fall),
  .run_o         (run_o),
  .paused_o      (paused_o)
);

// File: tb/dreq_pacer_bench.sv
module dreq_pacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [3:0] code;
    logic [5:0] unit;
    logic [7:0] units;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  6'd4,  8'd2},
    '{4'd0,  6'd4,  8'd1},
    '{4'd5,  6'd3,  8'd11},
    '{4'd10, 6'd32, 8'd32},
    '{4'd12, 6'd32, 8'd32},
    '{4'd2,  6'd1,  8'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_bit = 1'b0;
  logic       ext_start_en = 1'b0;
  logic       ext_pause_en = 1'b0;
  logic [3:0] req_code = '0;
  logic       start_pin = 1'b0;
  logic       dreq_n = 1'b1;
  logic       moved = 1'b0;
  logic [5:0] moved_bytes = '0;
  logic       run;
  logic       paused;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dreq_pacer u_dreq_pacer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_bit_i   (start_bit),
    .ext_start_en_i(ext_start_en),
    .ext_pause_en_i(ext_pause_en),
    .req_code_i    (req_code),
    .start_pin_i   (start_pin),
    .dreq_ni       (dreq_n),
    .moved_i       (moved),
    .moved_bytes_i (moved_bytes),
    .run_o         (run),
    .paused_o      (paused)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic got_run, input logic got_pause,
                       input logic exp_run, input logic exp_pause);
    checks++;
    if (got_run !== exp_run || got_pause !== exp_pause) begin
      errors++;
      $display("FAIL %s: run/paused got %b/%b expected %b/%b", req, got_run, got_pause,
               exp_run, exp_pause);
    end
  endtask

  task automatic move(input logic [5:0] b);
    moved = 1'b1;
    moved_bytes = b;
    tick();
    moved = 1'b0;
  endtask

  task automatic idle_all();
    start_bit = 1'b0;
    dreq_n = 1'b1;
    start_pin = 1'b0;
    tick(4);
  endtask

  task automatic start_paced(input logic [3:0] code);
    ext_start_en = 1'b0;
    ext_pause_en = 1'b1;
    req_code = code;
    start_bit = 1'b1;
    tick(3);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got running expected done");
    finish_run();
  end

  initial begin
    tick(2);
    check("R1", run, paused, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R1", run, paused, 1'b0, 1'b0);

    // table of bursts
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      vec_t  cur;
      cur = VECS[v];
      if (cur.code > 4'd10) tag = "R10";
      else if (32'(cur.units) * 32'(cur.unit) != (32'd1 << cur.code)) tag = "R8";
      else tag = "R6";
      idle_all();
      start_paced(cur.code);
      check("R5", run, paused, 1'b0, 1'b1);
      dreq_n = 1'b0;
      tick(4);
      check(tag, run, paused, 1'b1, 1'b0);
      for (int u = 0; u < int'(cur.units); u++) begin
        move(cur.unit);
        if (u == int'(cur.units) - 1) check(tag, run, paused, 1'b0, 1'b1);
        else if (run !== 1'b1) check(tag, run, paused, 1'b1, 1'b0);
      end
    end

    // R2 and R11: plain start, no pacing
    idle_all();
    ext_pause_en = 1'b0;
    ext_start_en = 1'b0;
    start_bit = 1'b1;
    tick(2);
    check("R2", run, paused, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) move(6'd32);
    check("R11", run, paused, 1'b1, 1'b0);

    // R4: clear start bit
    start_bit = 1'b0;
    tick();
    check("R4", run, paused, 1'b0, 1'b0);

    // R3: external start
    ext_start_en = 1'b1;
    start_bit = 1'b1;
    tick(6);
    check("R3", run, paused, 1'b0, 1'b0);
    start_pin = 1'b1;
    tick(4);
    check("R3", run, paused, 1'b1, 1'b0);
    ext_start_en = 1'b0;

    // R7: held-low request grants one burst only
    idle_all();
    start_paced(4'd2);
    dreq_n = 1'b0;
    tick(4);
    move(6'd4);
    check("R7", run, paused, 1'b0, 1'b1);
    tick(6);
    check("R7", run, paused, 1'b0, 1'b1);
    dreq_n = 1'b1;
    tick(4);
    dreq_n = 1'b0;
    tick(4);
    check("R7", run, paused, 1'b1, 1'b0);

    // R8: overshoot does not carry into the next burst
    idle_all();
    start_paced(4'd2);
    dreq_n = 1'b0;
    tick(4);
    move(6'd3);
    check("R8", run, paused, 1'b1, 1'b0);
    move(6'd3);
    check("R8", run, paused, 1'b0, 1'b1);
    dreq_n = 1'b1;
    tick(4);
    dreq_n = 1'b0;
    tick(4);
    for (int i = 0; i < 3; i++) move(6'd1);
    check("R8", run, paused, 1'b1, 1'b0);
    move(6'd1);
    check("R8", run, paused, 1'b0, 1'b1);

    // R9: request edge inside a burst is ignored
    idle_all();
    start_paced(4'd3);
    dreq_n = 1'b0;
    tick(4);
    move(6'd4);
    dreq_n = 1'b1;
    tick(4);
    dreq_n = 1'b0;
    tick(4);
    check("R9", run, paused, 1'b1, 1'b0);
    move(6'd4);
    check("R9", run, paused, 1'b0, 1'b1);

    idle_all();
    finish_run();
  end
endmodule